// File: doc/BRIEF.md
# Partition Freeze State Filter

This block keeps a pair of freeze flags for every isolation partition behind a host bridge and uses them to filter the traffic that passes through. Each transaction arrives with a partition number and a kind. When the governing flag of that partition is set, the block does three things. It stops writes from reaching their target. It completes reads with all-ones data. It withholds interrupt messages.

An error-report input freezes a partition by setting both of its flags in one cycle. Recovery software then thaws the memory-mapped side and the DMA side separately through a small register port. The same port reads back the flag pair of any partition. The details of the first error are held in a capture register until software releases it.

Top module: `part_freeze_filter`

## Requirements
- R1: After reset every partition has both flags clear and the error capture is empty (`cap_valid` low).
- R2: A cycle with `err_valid` high sets both the MMIO flag and the DMA flag of `err_part`. The new state governs traffic from the next cycle on.
- R3: `reg_clr_mmio` clears only the MMIO flag of `reg_part`, and `reg_clr_dma` clears only its DMA flag. The other flag and all other partitions keep their state.
- R4: If an error event and a clear hit the same partition in the same cycle, the partition ends up with both flags set.
- R5: A write (kind 1 = MMIO write, kind 3 = DMA write) to a frozen partition has `tx_fwd` low, so it does not reach its target.
- R6: A read (kind 0 = MMIO read, kind 2 = DMA read) to a frozen partition has `tx_fwd` low and `tx_rsp_data` all ones.
- R7: An interrupt message (kind 4) from a frozen partition has `tx_fwd` low.
- R8: Kinds 0 and 1 are governed by the MMIO flag. Kinds 2, 3 and 4 are governed by the DMA flag.
- R9: The capture stores the partition and code of the first error after it was empty, and later errors leave it unchanged. `reg_clr_cap` empties it. An error in the same cycle as `reg_clr_cap` is captured.
- R10: A `reg_rd` request returns `rd_valid` high exactly one cycle later. `rd_mmio` and `rd_dma` show the flags of `reg_part` as they stood in the request cycle.
- R11: Traffic to an unfrozen partition has `tx_fwd` equal to `tx_valid`, and `tx_rsp_data` equal to `tx_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error event that freezes a partition |
| err_part | input | PART_W | Partition hit by the error |
| err_code | input | CODE_W | Error detail to capture |
| reg_part | input | PART_W | Partition addressed by the register port |
| reg_clr_mmio | input | 1 | Clear the MMIO flag of `reg_part` |
| reg_clr_dma | input | 1 | Clear the DMA flag of `reg_part` |
| reg_clr_cap | input | 1 | Empty the error capture |
| reg_rd | input | 1 | Read back the flags of `reg_part` |
| rd_valid | output | 1 | Read-back result valid |
| rd_mmio | output | 1 | Read-back MMIO flag |
| rd_dma | output | 1 | Read-back DMA flag |
| cap_valid | output | 1 | Capture holds an error |
| cap_part | output | PART_W | Captured partition |
| cap_code | output | CODE_W | Captured error code |
| tx_valid | input | 1 | Transaction present |
| tx_kind | input | 3 | Transaction kind (0 MMIO read, 1 MMIO write, 2 DMA read, 3 DMA write, 4 interrupt) |
| tx_part | input | PART_W | Partition of the transaction |
| tx_rdata | input | DATA_W | Read data from the target |
| tx_fwd | output | 1 | Transaction allowed through |
| tx_rsp_data | output | DATA_W | Read completion data |

## Verification
The bench first freezes a partition and then sends every kind of traffic to it and to its neighbours. If the filter looked up the wrong flag per kind, a DMA read would return real data after only the MMIO side was thawed. It races an error against a clear on one partition, so a design that let the clear win would show the partition as thawed. It raises a second error and then an error in the same cycle as the capture release. An overwriting capture, or one that loses the same-cycle error, shows the wrong partition and code. It also uses partitions 0 and 255 and reads back in the cycle a flag changes, which catches an off-by-one index and a read that returns post-update values.

// File: rtl/pfz_pkg.sv
package pfz_pkg;

    localparam int unsigned PFZ_NUM_PART = 256;
    localparam int unsigned PFZ_DATA_W   = 32;
    localparam int unsigned PFZ_CODE_W   = 16;
    localparam int unsigned PFZ_KIND_W   = 3;

    typedef enum logic [PFZ_KIND_W-1:0] {
        TK_MMIO_RD = 3'd0,
        TK_MMIO_WR = 3'd1,
        TK_DMA_RD  = 3'd2,
        TK_DMA_WR  = 3'd3,
        TK_MSI     = 3'd4
    } txn_kind_e;

    // Kind is governed by the DMA-side flag
    function automatic logic kind_on_dma(input txn_kind_e k);
        return (k == TK_DMA_RD) || (k == TK_DMA_WR) || (k == TK_MSI);
    endfunction

    function automatic logic kind_is_read(input txn_kind_e k);
        return (k == TK_MMIO_RD) || (k == TK_DMA_RD);
    endfunction

endpackage

// File: rtl/pfz_flag_bank.sv
module pfz_flag_bank #(
    parameter int unsigned NUM_PART = 256,
    localparam int unsigned PART_W  = $clog2(NUM_PART)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [PART_W-1:0]   set_part,
    input  logic                clr_mmio,
    input  logic                clr_dma,
    input  logic [PART_W-1:0]   clr_part,
    input  logic                rd_en,
    input  logic [PART_W-1:0]   rd_part,
    output logic                rd_valid,
    output logic                rd_mmio,
    output logic                rd_dma,
    output logic [NUM_PART-1:0] mmio_vec,
    output logic [NUM_PART-1:0] dma_vec
);

    for (genvar p = 0; p < NUM_PART; p++) begin : g_part
        logic hit_set, hit_clr;
        assign hit_set = set_en && (set_part == PART_W'(p));
        assign hit_clr = (clr_part == PART_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                mmio_vec[p] <= 1'b0;
                dma_vec[p]  <= 1'b0;
            end else if (hit_set) begin
                mmio_vec[p] <= 1'b1;
                dma_vec[p]  <= 1'b1;
            end else begin
                if (hit_clr && clr_mmio) mmio_vec[p] <= 1'b0;
                if (hit_clr && clr_dma)  dma_vec[p]  <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_mmio  <= 1'b0;
            rd_dma   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_mmio <= mmio_vec[rd_part];
                rd_dma  <= dma_vec[rd_part];
            end
        end
    end

endmodule

// File: rtl/pfz_err_capture.sv
module pfz_err_capture #(
    parameter int unsigned PART_W = 8,
    parameter int unsigned CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_valid,
    input  logic [PART_W-1:0] err_part,
    input  logic [CODE_W-1:0] err_code,
    input  logic              release_cap,
    output logic              cap_valid,
    output logic [PART_W-1:0] cap_part,
    output logic [CODE_W-1:0] cap_code
);

    typedef struct packed {
        logic              valid;
        logic [PART_W-1:0] part;
        logic [CODE_W-1:0] code;
    } cap_t;

    cap_t cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (err_valid && (!cap_q.valid || release_cap)) begin
            cap_q <= '{valid: 1'b1, part: err_part, code: err_code};
        end else if (release_cap) begin
            cap_q.valid <= 1'b0;
        end
    end

    assign cap_valid = cap_q.valid;
    assign cap_part  = cap_q.part;
    assign cap_code  = cap_q.code;

endmodule

// File: rtl/pfz_txn_gate.sv
module pfz_txn_gate
    import pfz_pkg::*;
#(
    parameter int unsigned NUM_PART = 256,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned PART_W  = $clog2(NUM_PART)
) (
    input  logic [NUM_PART-1:0]   mmio_vec,
    input  logic [NUM_PART-1:0]   dma_vec,
    input  logic                  tx_valid,
    input  logic [PFZ_KIND_W-1:0] tx_kind,
    input  logic [PART_W-1:0]     tx_part,
    input  logic [DATA_W-1:0]     tx_rdata,
    output logic                  tx_fwd,
    output logic [DATA_W-1:0]     tx_rsp_data
);

    txn_kind_e kind;
    logic      frozen;

    always_comb begin
        kind   = txn_kind_e'(tx_kind);
        frozen = kind_on_dma(kind) ? dma_vec[tx_part] : mmio_vec[tx_part];
        tx_fwd = tx_valid && !frozen;
        if (frozen && kind_is_read(kind)) tx_rsp_data = '1;
        else                              tx_rsp_data = tx_rdata;
    end

endmodule

// File: rtl/part_freeze_filter.sv
module part_freeze_filter
    import pfz_pkg::*;
#(
    parameter int unsigned NUM_PART = PFZ_NUM_PART,
    parameter int unsigned DATA_W   = PFZ_DATA_W,
    parameter int unsigned CODE_W   = PFZ_CODE_W,
    localparam int unsigned PART_W  = $clog2(NUM_PART)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  err_valid,
    input  logic [PART_W-1:0]     err_part,
    input  logic [CODE_W-1:0]     err_code,
    input  logic [PART_W-1:0]     reg_part,
    input  logic                  reg_clr_mmio,
    input  logic                  reg_clr_dma,
    input  logic                  reg_clr_cap,
    input  logic                  reg_rd,
    output logic                  rd_valid,
    output logic                  rd_mmio,
    output logic                  rd_dma,
    output logic                  cap_valid,
    output logic [PART_W-1:0]     cap_part,
    output logic [CODE_W-1:0]     cap_code,
    input  logic                  tx_valid,
    input  logic [PFZ_KIND_W-1:0] tx_kind,
    input  logic [PART_W-1:0]     tx_part,
    input  logic [DATA_W-1:0]     tx_rdata,
    output logic                  tx_fwd,
    output logic [DATA_W-1:0]     tx_rsp_data
);

    logic [NUM_PART-1:0] frz_mmio;
    logic [NUM_PART-1:0] frz_dma;

    pfz_flag_bank #(.NUM_PART(NUM_PART)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_en   (err_valid),
        .set_part (err_part),
        .clr_mmio (reg_clr_mmio),
        .clr_dma  (reg_clr_dma),
        .clr_part (reg_part),
        .rd_en    (reg_rd),
        .rd_part  (reg_part),
        .rd_valid (rd_valid),
        .rd_mmio  (rd_mmio),
        .rd_dma   (rd_dma),
        .mmio_vec (frz_mmio),
        .dma_vec  (frz_dma)
    );

    pfz_err_capture #(.PART_W(PART_W), .CODE_W(CODE_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .err_valid   (err_valid),
        .err_part    (err_part),
        .err_code    (err_code),
        .release_cap (reg_clr_cap),
        .cap_valid   (cap_valid),
        .cap_part    (cap_part),
        .cap_code    (cap_code)
    );

    pfz_txn_gate #(.NUM_PART(NUM_PART), .DATA_W(DATA_W)) u_gate (
        .mmio_vec    (frz_mmio),
        .dma_vec     (frz_dma),
        .tx_valid    (tx_valid),
        .tx_kind     (tx_kind),
        .tx_part     (tx_part),
        .tx_rdata    (tx_rdata),
        .tx_fwd      (tx_fwd),
        .tx_rsp_data (tx_rsp_data)
    );

endmodule

// File: rtl/part_freeze_filter_chk.sv
module part_freeze_filter_chk #(
    parameter int unsigned NUM_PART = 256,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CODE_W   = 16,
    localparam int unsigned PART_W  = $clog2(NUM_PART)
) (
    input logic                clk,
    input logic                rst,
    input logic                err_valid,
    input logic [PART_W-1:0]   err_part,
    input logic [PART_W-1:0]   reg_part,
    input logic                reg_clr_mmio,
    input logic                reg_clr_dma,
    input logic                reg_clr_cap,
    input logic                reg_rd,
    input logic                rd_valid,
    input logic                cap_valid,
    input logic [PART_W-1:0]   cap_part,
    input logic [CODE_W-1:0]   cap_code,
    input logic                tx_valid,
    input logic [2:0]          tx_kind,
    input logic [PART_W-1:0]   tx_part,
    input logic                tx_fwd,
    input logic [DATA_W-1:0]   tx_rsp_data,
    input logic [NUM_PART-1:0] frz_mmio,
    input logic [NUM_PART-1:0] frz_dma
);

    // R2, R4: an error event leaves both flags set
    a_r2_set_both: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> (frz_mmio[$past(err_part)] && frz_dma[$past(err_part)]));

    // R3: clearing MMIO alone keeps the DMA flag
    a_r3_dma_kept: assert property (@(posedge clk) disable iff (rst)
        (reg_clr_mmio && !reg_clr_dma && !err_valid)
        |=> (frz_dma[$past(reg_part)] == $past(frz_dma[reg_part])));

    // R5: frozen MMIO write is dropped
    a_r5_wr_drop: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind == 3'd1 && frz_mmio[tx_part]) |-> !tx_fwd);

    // R6: frozen DMA read returns all ones
    a_r6_rd_ones: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind == 3'd2 && frz_dma[tx_part]) |-> (tx_rsp_data == '1));

    // R7: frozen interrupt is withheld
    a_r7_msi_block: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_kind == 3'd4 && frz_dma[tx_part]) |-> !tx_fwd);

    // R9: a held capture stays put until released
    a_r9_cap_hold: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !reg_clr_cap) |=> (cap_valid && $stable(cap_part) && $stable(cap_code)));

    // R10: read-back answers exactly one cycle later
    a_r10_rd_lat: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> rd_valid);
    a_r10_rd_quiet: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !rd_valid);

endmodule

bind part_freeze_filter part_freeze_filter_chk #(
    .NUM_PART(NUM_PART), .DATA_W(DATA_W), .CODE_W(CODE_W)
) u_chk (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_part(err_part),
    .reg_part(reg_part), .reg_clr_mmio(reg_clr_mmio), .reg_clr_dma(reg_clr_dma),
    .reg_clr_cap(reg_clr_cap), .reg_rd(reg_rd), .rd_valid(rd_valid),
    .cap_valid(cap_valid), .cap_part(cap_part), .cap_code(cap_code),
    .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_part(tx_part), .tx_fwd(tx_fwd),
    .tx_rsp_data(tx_rsp_data), .frz_mmio(frz_mmio), .frz_dma(frz_dma)
);

// File: tb/part_freeze_filter_tb.sv
module part_freeze_filter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        err_valid;
    logic [7:0]  err_part;
    logic [15:0] err_code;
    logic [7:0]  reg_part;
    logic        reg_clr_mmio, reg_clr_dma, reg_clr_cap, reg_rd;
    logic        rd_valid, rd_mmio, rd_dma;
    logic        cap_valid;
    logic [7:0]  cap_part;
    logic [15:0] cap_code;
    logic        tx_valid;
    logic [2:0]  tx_kind;
    logic [7:0]  tx_part;
    logic [31:0] tx_rdata;
    logic        tx_fwd;
    logic [31:0] tx_rsp_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    part_freeze_filter u_dut (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_part(err_part),
        .err_code(err_code), .reg_part(reg_part), .reg_clr_mmio(reg_clr_mmio),
        .reg_clr_dma(reg_clr_dma), .reg_clr_cap(reg_clr_cap), .reg_rd(reg_rd),
        .rd_valid(rd_valid), .rd_mmio(rd_mmio), .rd_dma(rd_dma),
        .cap_valid(cap_valid), .cap_part(cap_part), .cap_code(cap_code),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_part(tx_part),
        .tx_rdata(tx_rdata), .tx_fwd(tx_fwd), .tx_rsp_data(tx_rsp_data)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [7:0]  part;
        logic [31:0] rdata;
        logic        fwd;
        logic [31:0] rsp;
    } vec_t;

    // Partition 5 frozen (both flags); everything else thawed
    localparam vec_t VEC [8] = '{
        '{3'd1, 8'd5, 32'h1111_0000, 1'b0, 32'h1111_0000},  // R5 MMIO write
        '{3'd0, 8'd5, 32'h2222_0000, 1'b0, 32'hFFFF_FFFF},  // R6 MMIO read
        '{3'd3, 8'd5, 32'h3333_0000, 1'b0, 32'h3333_0000},  // R5 DMA write
        '{3'd2, 8'd5, 32'h4444_0000, 1'b0, 32'hFFFF_FFFF},  // R6 DMA read
        '{3'd4, 8'd5, 32'h5555_0000, 1'b0, 32'h5555_0000},  // R7 interrupt
        '{3'd0, 8'd6, 32'h6666_0000, 1'b1, 32'h6666_0000},  // R11 neighbour
        '{3'd2, 8'd4, 32'h7777_0000, 1'b1, 32'h7777_0000},  // R11 neighbour
        '{3'd4, 8'd6, 32'h8888_0000, 1'b1, 32'h8888_0000}   // R11 neighbour
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        err_valid = 0; reg_clr_mmio = 0; reg_clr_dma = 0; reg_clr_cap = 0;
        reg_rd = 0; tx_valid = 0;
    endtask

    task automatic raise_err(input logic [7:0] p, input logic [15:0] c);
        @(negedge clk);
        err_valid = 1; err_part = p; err_code = c;
        @(negedge clk);
        err_valid = 0;
    endtask

    task automatic readback(input logic [7:0] p, input string req,
                            input logic em, input logic ed);
        @(negedge clk);
        reg_rd = 1; reg_part = p;
        @(posedge clk); #1;
        chk(req, {31'd0, rd_valid}, 32'd1);
        chk(req, {30'd0, rd_mmio, rd_dma}, {30'd0, em, ed});
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic send(input logic [2:0] k, input logic [7:0] p, input logic [31:0] d,
                        input string req, input logic ef, input logic [31:0] er);
        @(negedge clk);
        tx_valid = 1; tx_kind = k; tx_part = p; tx_rdata = d;
        #1;
        chk(req, {31'd0, tx_fwd}, {31'd0, ef});
        chk(req, tx_rsp_data, er);
        @(negedge clk);
        tx_valid = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        err_part = 0; err_code = 0; reg_part = 0; tx_kind = 0; tx_part = 0; tx_rdata = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        #1 chk("R1 cap", {31'd0, cap_valid}, 32'd0);
        readback(8'd5, "R1 flags", 1'b0, 1'b0);
        send(3'd0, 8'd5, 32'hCAFE_0001, "R11 pre-freeze", 1'b1, 32'hCAFE_0001);

        // R2 freeze partition 5
        raise_err(8'd5, 16'h0ABC);
        readback(8'd5, "R2 both set", 1'b1, 1'b1);
        chk("R9 first cap valid", {31'd0, cap_valid}, 32'd1);
        chk("R9 first cap", {8'd0, cap_part, cap_code}, {8'd0, 8'd5, 16'h0ABC});

        // Table walk: R5 R6 R7 R11
        for (int i = 0; i < 8; i++)
            send(VEC[i].kind, VEC[i].part, VEC[i].rdata, "R5/R6/R7/R11 table",
                 VEC[i].fwd, VEC[i].rsp);

        // R3 clear MMIO only; R10 readback in clear cycle shows old values
        @(negedge clk);
        reg_clr_mmio = 1; reg_part = 8'd5; reg_rd = 1;
        @(posedge clk); #1;
        chk("R10 pre-update", {30'd0, rd_mmio, rd_dma}, 32'd3);
        @(negedge clk); reg_clr_mmio = 0; reg_rd = 0;
        readback(8'd5, "R3 mmio only", 1'b0, 1'b1);
        // R8 selection by kind
        send(3'd0, 8'd5, 32'h0000_00A1, "R8 mmio rd thawed", 1'b1, 32'h0000_00A1);
        send(3'd2, 8'd5, 32'h0000_00A2, "R8 dma rd frozen", 1'b0, 32'hFFFF_FFFF);
        send(3'd4, 8'd5, 32'h0000_00A3, "R8 msi frozen", 1'b0, 32'h0000_00A3);
        // R3 clear DMA
        @(negedge clk); reg_clr_dma = 1; reg_part = 8'd5;
        @(negedge clk); reg_clr_dma = 0;
        readback(8'd5, "R3 dma cleared", 1'b0, 1'b0);

        // R9 second error does not overwrite
        raise_err(8'd9, 16'h0002);
        chk("R9 hold", {8'd0, cap_part, cap_code}, {8'd0, 8'd5, 16'h0ABC});
        // R9 release with same-cycle error captures the new one
        @(negedge clk);
        reg_clr_cap = 1; err_valid = 1; err_part = 8'd255; err_code = 16'h00FF;
        @(negedge clk);
        reg_clr_cap = 0; err_valid = 0;
        chk("R9 same-cycle", {7'd0, cap_valid, cap_part, cap_code}, {7'd0, 1'b1, 8'd255, 16'h00FF});
        @(negedge clk); reg_clr_cap = 1;
        @(negedge clk); reg_clr_cap = 0;
        chk("R9 released", {31'd0, cap_valid}, 32'd0);
        readback(8'd255, "R2 top partition", 1'b1, 1'b1);
        readback(8'd0, "R2 partition 0 untouched", 1'b0, 1'b0);

        // R4 set and clear on the same partition in one cycle
        @(negedge clk);
        err_valid = 1; err_part = 8'd12; err_code = 16'h0012;
        reg_clr_mmio = 1; reg_clr_dma = 1; reg_part = 8'd12;
        @(negedge clk);
        idle();
        readback(8'd12, "R4 set wins", 1'b1, 1'b1);
        send(3'd3, 8'd12, 32'h0, "R4 write dropped", 1'b0, 32'h0);

        @(negedge clk);
        chk("R10 idle", {31'd0, rd_valid}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule